// File: doc/BRIEF.md
# Tile Hidden Surface Removal Unit

This block resolves visibility for one square screen tile at a time before any shading work is issued. A tile begins with a start command, which wipes an on-chip depth store and an on-chip owner-tag store. Already-binned coverage records then arrive on a valid/ready stream. Each record carries a pixel position inside the tile, a depth and a primitive identifier. Every record goes through a single-cycle read-modify-write depth test. The winner's identifier is written into the tag store, so after the last record each pixel holds exactly the primitive that is closest there.

When the tile-end marker arrives, the input stream is closed. The block then sweeps the tag store once for each distinct primitive seen in the tile and emits `(primitive, x, y)` records on a valid/ready output stream. The records come out grouped by primitive, which lets a downstream shading stage fetch attributes only for fragments that survived and keep one primitive's state resident for a whole group. Position data is the only input; no attribute is ever requested for a hidden fragment.

Top module: `tile_hsr`

## Requirements
- R1: A `tile_start` pulse seen while `tile_busy` is low raises `tile_busy`. The block then spends 1024 cycles setting every depth entry of the 32x32 tile to all ones and every tag to the invalid code, and only then raises `in_ready`. The first edge after the edge that sampled the start is clear cycle one. A `tile_start` seen while `tile_busy` is high is ignored.
- R2: A record wins its pixel only if its depth is strictly less than the stored depth. A depth of all ones therefore never claims a cleared pixel.
- R3: If two records for a pixel have equal depth, the one accepted first keeps the pixel.
- R4: The identifier with all bits set (255 at the default 8-bit width) is the invalid tag. Records carrying it are discarded, and pixels never won are never emitted.
- R5: The output comes in groups, one per distinct primitive, in the order each primitive's identifier was first accepted in the tile. Within a group, pixels come in ascending raster index y*32+x. Each visible pixel appears exactly once.
- R6: When all depths at a pixel are distinct, the set of emitted (primitive, x, y) records does not depend on the order in which the records were submitted.
- R7: While `out_valid` is high and `out_ready` is low, the output record is held unchanged.
- R8: `tile_end` is taken only while `in_ready` is high. From the next cycle, `in_ready` stays low until the tile finishes and `tile_busy` falls.
- R9: At most 16 distinct identifiers are tracked per tile. A record whose identifier is new once 16 are tracked is discarded.
- R10: A tile in which no pixel was won finishes with no output record and returns to idle.
- R11: After reset, `tile_busy`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tile_start | input | 1 | Begin a new tile (taken only when idle) |
| tile_busy | output | 1 | High from accepted start until the last output record leaves |
| in_valid | input | 1 | Coverage record valid |
| in_ready | output | 1 | Coverage stream can accept a record |
| in_x | input | 5 | Pixel column within the tile |
| in_y | input | 5 | Pixel row within the tile |
| in_depth | input | 16 | Depth, smaller is nearer |
| in_prim | input | 8 | Primitive identifier |
| tile_end | input | 1 | Last record of the tile has been sent |
| out_valid | output | 1 | Visible fragment record valid |
| out_ready | input | 1 | Consumer accepts the output record |
| out_prim | output | 8 | Owning primitive of the fragment |
| out_x | output | 5 | Pixel column |
| out_y | output | 5 | Pixel row |

## Verification
Directed tiles stack two primitives on the same pixels with equal depths, and with an all-ones depth on an empty pixel. These separate a less-than test from a less-or-equal test, and first-writer ownership from last-writer ownership. One scene is sent forward and then reversed with unique depths; matching pixel owners show order independence, while the changed group order shows that grouping follows first appearance. Random tiles with dense overlap, small depth ranges and sprinkled invalid identifiers exercise the read-modify-write path. Two further tiles are checked: one with seventeen identifiers and one where nothing is visible. Random output stalls throughout show whether records are held or lost under backpressure.

// File: rtl/tile_hsr_pkg.sv
package tile_hsr_pkg;
   typedef enum logic [2:0] {
      HS_IDLE  = 3'd0,
      HS_CLEAR = 3'd1,
      HS_TAKE  = 3'd2,
      HS_SCAN  = 3'd3,
      HS_DRAIN = 3'd4
   } hsr_state_t;
endpackage

// File: rtl/hsr_id_list.sv
module hsr_id_list #(
   parameter int ID_W       = 8,
   parameter int LIST_DEPTH = 16,
   localparam int LIST_W    = $clog2(LIST_DEPTH),
   localparam int COUNT_W   = LIST_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               look_en,
   input  logic [ID_W-1:0]    look_id,
   output logic               keep,
   input  logic [LIST_W-1:0]  rd_idx,
   output logic [ID_W-1:0]    rd_id,
   output logic [COUNT_W-1:0] count
);
   logic [ID_W-1:0]       ids [LIST_DEPTH];
   logic [LIST_DEPTH-1:0] match;
   logic                  hit;
   logic                  full;

   for (genvar i = 0; i < LIST_DEPTH; i++) begin : g_cmp
      assign match[i] = (COUNT_W'(i) < count) && (ids[i] == look_id);
   end

   assign hit   = |match;
   assign full  = (count == COUNT_W'(LIST_DEPTH));
   assign keep  = hit || !full;
   assign rd_id = ids[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (look_en && !hit && !full) begin
         count <= count + COUNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (look_en && !hit && !full && !clear) begin
         ids[count[LIST_W-1:0]] <= look_id;
      end
   end
endmodule

// File: rtl/hsr_pixel_store.sv
module hsr_pixel_store #(
   parameter int ADDR_W  = 10,
   parameter int DEPTH_W = 16,
   parameter int ID_W    = 8,
   localparam int PIX    = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               clr_en,
   input  logic [ADDR_W-1:0]  clr_addr,
   input  logic               acc_en,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DEPTH_W-1:0] acc_depth,
   input  logic [ID_W-1:0]    acc_id,
   input  logic [ADDR_W-1:0]  scan_addr,
   output logic [ID_W-1:0]    scan_id
);
   logic [DEPTH_W-1:0] depth_mem [PIX];
   logic [ID_W-1:0]    tag_mem   [PIX];
   logic               nearer;

   assign nearer  = acc_depth < depth_mem[acc_addr];
   assign scan_id = tag_mem[scan_addr];

   always_ff @(posedge clk) begin
      if (clr_en) begin
         depth_mem[clr_addr] <= '1;
         tag_mem[clr_addr]   <= '1;
      end else if (acc_en && nearer) begin
         depth_mem[acc_addr] <= acc_depth;
         tag_mem[acc_addr]   <= acc_id;
      end
   end
endmodule

// File: rtl/tile_hsr.sv
module tile_hsr
   import tile_hsr_pkg::*;
#(
   parameter int X_W        = 5,
   parameter int Y_W        = 5,
   parameter int DEPTH_W    = 16,
   parameter int ID_W       = 8,
   parameter int LIST_DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tile_start,
   output logic               tile_busy,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [X_W-1:0]     in_x,
   input  logic [Y_W-1:0]     in_y,
   input  logic [DEPTH_W-1:0] in_depth,
   input  logic [ID_W-1:0]    in_prim,
   input  logic               tile_end,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [ID_W-1:0]    out_prim,
   output logic [X_W-1:0]     out_x,
   output logic [Y_W-1:0]     out_y
);
   localparam int PIX_W   = X_W + Y_W;
   localparam int LIST_W  = $clog2(LIST_DEPTH);
   localparam int COUNT_W = LIST_W + 1;
   localparam logic [PIX_W-1:0] LAST_PIX = '1;
   localparam logic [ID_W-1:0]  NO_TAG   = '1;

   if (X_W < 1 || Y_W < 1 || PIX_W > 12) begin : g_bad_tile
      $error("tile_hsr: tile dimensions out of range");
   end
   if (DEPTH_W < 2) begin : g_bad_depth
      $error("tile_hsr: DEPTH_W too small");
   end
   if (LIST_DEPTH < 2 || (1 << LIST_W) != LIST_DEPTH || LIST_DEPTH >= (1 << ID_W)) begin : g_bad_list
      $error("tile_hsr: LIST_DEPTH must be a power of two below 2**ID_W");
   end

   hsr_state_t         state;
   logic [PIX_W-1:0]   clr_cnt;
   logic [PIX_W-1:0]   pix;
   logic [LIST_W-1:0]  grp;
   logic               accept;
   logic               id_ok;
   logic               keep;
   logic [COUNT_W-1:0] id_count;
   logic [ID_W-1:0]    grp_id;
   logic [ID_W-1:0]    pix_id;
   logic               pix_hit;
   logic               out_free;
   logic               last_grp;
   logic               start_ok;

   assign start_ok  = tile_start && (state == HS_IDLE);
   assign in_ready  = (state == HS_TAKE);
   assign tile_busy = (state != HS_IDLE);
   assign accept    = in_valid && in_ready;
   assign id_ok     = (in_prim != NO_TAG);
   assign pix_hit   = (pix_id == grp_id);
   assign out_free  = !out_valid || out_ready;
   assign last_grp  = ({1'b0, grp} == id_count - COUNT_W'(1));

   hsr_id_list #(
      .ID_W       (ID_W),
      .LIST_DEPTH (LIST_DEPTH)
   ) u_ids (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .look_en (accept && id_ok),
      .look_id (in_prim),
      .keep    (keep),
      .rd_idx  (grp),
      .rd_id   (grp_id),
      .count   (id_count)
   );

   hsr_pixel_store #(
      .ADDR_W  (PIX_W),
      .DEPTH_W (DEPTH_W),
      .ID_W    (ID_W)
   ) u_store (
      .clk       (clk),
      .clr_en    (state == HS_CLEAR),
      .clr_addr  (clr_cnt),
      .acc_en    (accept && id_ok && keep),
      .acc_addr  ({in_y, in_x}),
      .acc_depth (in_depth),
      .acc_id    (in_prim),
      .scan_addr (pix),
      .scan_id   (pix_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= HS_IDLE;
         clr_cnt   <= '0;
         pix       <= '0;
         grp       <= '0;
         out_valid <= 1'b0;
         out_prim  <= '0;
         out_x     <= '0;
         out_y     <= '0;
      end else begin
         unique case (state)
            HS_IDLE: begin
               if (start_ok) begin
                  state   <= HS_CLEAR;
                  clr_cnt <= '0;
               end
            end
            HS_CLEAR: begin
               clr_cnt <= clr_cnt + PIX_W'(1);
               if (clr_cnt == LAST_PIX) state <= HS_TAKE;
            end
            HS_TAKE: begin
               if (tile_end) begin
                  state <= HS_SCAN;
                  pix   <= '0;
                  grp   <= '0;
               end
            end
            HS_SCAN: begin
               if (id_count == '0) begin
                  state <= HS_IDLE;
               end else if (out_free) begin
                  out_valid <= pix_hit;
                  if (pix_hit) begin
                     out_prim <= grp_id;
                     out_x    <= pix[X_W-1:0];
                     out_y    <= pix[PIX_W-1:X_W];
                  end
                  pix <= pix + PIX_W'(1);
                  if (pix == LAST_PIX) begin
                     if (last_grp) state <= HS_DRAIN;
                     else          grp   <= grp + LIST_W'(1);
                  end
               end
            end
            HS_DRAIN: begin
               if (out_free) begin
                  out_valid <= 1'b0;
                  state     <= HS_IDLE;
               end
            end
            default: state <= HS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tile_hsr_checker.sv
module tile_hsr_checker #(
   parameter int X_W  = 5,
   parameter int Y_W  = 5,
   parameter int ID_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tile_start,
   input logic            tile_busy,
   input logic            in_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic [ID_W-1:0] out_prim,
   input logic [X_W-1:0]  out_x,
   input logic [Y_W-1:0]  out_y
);
   assert_start_enters_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_start && !tile_busy) |=> (tile_busy && !in_ready));

   assert_no_invalid_tag_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_prim != {ID_W{1'b1}}));

   assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_prim) && $stable(out_x) && $stable(out_y)));

   assert_input_closed_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_idle_is_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tile_busy |-> (!out_valid && !in_ready));
endmodule

bind tile_hsr tile_hsr_checker #(
   .X_W  (X_W),
   .Y_W  (Y_W),
   .ID_W (ID_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tile_start (tile_start),
   .tile_busy  (tile_busy),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_prim   (out_prim),
   .out_x      (out_x),
   .out_y      (out_y)
);

// File: tb/tile_hsr_test.sv
module tile_hsr_test;
   localparam int NPIX = 1024;
   localparam int MAXR = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tile_start = 1'b0;
   logic        tile_busy;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [4:0]  in_x = '0;
   logic [4:0]  in_y = '0;
   logic [15:0] in_depth = '0;
   logic [7:0]  in_prim = '0;
   logic        tile_end = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_prim;
   logic [4:0]  out_x;
   logic [4:0]  out_y;

   always #5 clk = ~clk;

   tile_hsr uut (
      .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .tile_busy(tile_busy),
      .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
      .in_depth(in_depth), .in_prim(in_prim), .tile_end(tile_end),
      .out_valid(out_valid), .out_ready(out_ready), .out_prim(out_prim),
      .out_x(out_x), .out_y(out_y)
   );

   int checks = 0;
   int errors = 0;
   int seed_dummy;

   int rx [MAXR];
   int ry [MAXR];
   int rd [MAXR];
   int rp [MAXR];
   int nrec;

   int e_dep [NPIX];
   int e_tag [NPIX];
   int lst [16];
   int lc;
   int ep [NPIX];
   int ei [NPIX];
   int en;

   int gp [NPIX];
   int gi [NPIX];
   int gn;
   int own_a [NPIX];
   int clr_cycles;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic build_expect();
      for (int p = 0; p < NPIX; p++) begin
         e_dep[p] = 65535;
         e_tag[p] = -1;
      end
      lc = 0;
      for (int r = 0; r < nrec; r++) begin
         int a;
         bit known;
         if (rp[r] == 255) continue;
         known = 0;
         for (int k = 0; k < lc; k++) if (lst[k] == rp[r]) known = 1;
         if (!known) begin
            if (lc == 16) continue;
            lst[lc] = rp[r];
            lc++;
         end
         a = ry[r] * 32 + rx[r];
         if (rd[r] < e_dep[a]) begin
            e_dep[a] = rd[r];
            e_tag[a] = rp[r];
         end
      end
      en = 0;
      for (int k = 0; k < lc; k++)
         for (int p = 0; p < NPIX; p++)
            if (e_tag[p] == lst[k]) begin
               ep[en] = lst[k];
               ei[en] = p;
               en++;
            end
   endtask

   task automatic run_tile(input string req, input bit poke_start);
      int cnt;
      @(negedge clk);
      tile_start = 1'b1;
      cnt = 0;
      @(posedge clk);
      cnt++;
      @(negedge clk);
      tile_start = 1'b0;
      while (!in_ready) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
      end
      clr_cycles = cnt;
      if (poke_start) begin
         tile_start = 1'b1;
         @(negedge clk);
         tile_start = 1'b0;
         check(in_ready === 1'b1, "R1 start ignored while busy", int'(in_ready), 1);
      end
      for (int r = 0; r < nrec; r++) begin
         if ($urandom_range(0, 3) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_x = 5'(rx[r]);
         in_y = 5'(ry[r]);
         in_depth = 16'(rd[r]);
         in_prim = 8'(rp[r]);
         @(negedge clk);
      end
      in_valid = 1'b0;
      tile_end = 1'b1;
      @(negedge clk);
      tile_end = 1'b0;
      check(in_ready === 1'b0, {req, " R8 input closed after tile end"}, int'(in_ready), 0);
      gn = 0;
      while (tile_busy) begin
         @(negedge clk);
         if (in_ready) check(1'b0, "R8 in_ready during scan", 1, 0);
         out_ready = ($urandom_range(0, 2) != 0);
         #1;
         if (out_valid && out_ready && gn < NPIX) begin
            gp[gn] = int'(out_prim);
            gi[gn] = int'(out_y) * 32 + int'(out_x);
            gn++;
         end
      end
      out_ready = 1'b0;
      build_expect();
      check(gn == en, {req, " output count"}, gn, en);
      for (int i = 0; i < gn && i < en; i++) begin
         check(gp[i] == ep[i] && gi[i] == ei[i], {req, " R5 record prim*1024+pixel"},
               gp[i] * 1024 + gi[i], ep[i] * 1024 + ei[i]);
      end
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 190000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check(tile_busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0,
            "R11 reset state", int'({tile_busy, in_ready, out_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: ties keep first writer, all-ones depth never claims a pixel
      nrec = 5;
      rx[0] = 3; ry[0] = 2; rd[0] = 10; rp[0] = 7;
      rx[1] = 3; ry[1] = 2; rd[1] = 10; rp[1] = 9;
      rx[2] = 4; ry[2] = 2; rd[2] = 20; rp[2] = 9;
      rx[3] = 4; ry[3] = 2; rd[3] = 19; rp[3] = 7;
      rx[4] = 5; ry[4] = 2; rd[4] = 65535; rp[4] = 9;
      run_tile("R3 tie", 1'b1);
      check(clr_cycles == 1025, "R1 clear sweep length", clr_cycles, 1025);
      check(gn == 2 && gp[0] == 7 && gi[0] == 67, "R3 tie keeps first", gp[0], 7);
      check(gi[1] == 68 && gp[1] == 7, "R2 strictly nearer wins", gp[1], 7);

      // R6: same scene forward then reversed, unique depths
      nrec = 200;
      for (int r = 0; r < nrec; r++) begin
         rx[r] = $urandom_range(0, 7);
         ry[r] = $urandom_range(0, 7);
         rd[r] = (r * 37) % 1000;
         rp[r] = 20 + (r % 4);
      end
      run_tile("R6 forward", 1'b0);
      for (int p = 0; p < NPIX; p++) own_a[p] = -1;
      for (int i = 0; i < gn; i++) own_a[gi[i]] = gp[i];
      for (int r = 0; r < nrec / 2; r++) begin
         int t;
         t = rx[r]; rx[r] = rx[nrec-1-r]; rx[nrec-1-r] = t;
         t = ry[r]; ry[r] = ry[nrec-1-r]; ry[nrec-1-r] = t;
         t = rd[r]; rd[r] = rd[nrec-1-r]; rd[nrec-1-r] = t;
         t = rp[r]; rp[r] = rp[nrec-1-r]; rp[nrec-1-r] = t;
      end
      run_tile("R6 reverse", 1'b0);
      begin
         int diff;
         int own_b [NPIX];
         diff = 0;
         for (int p = 0; p < NPIX; p++) own_b[p] = -1;
         for (int i = 0; i < gn; i++) own_b[gi[i]] = gp[i];
         for (int p = 0; p < NPIX; p++) if (own_a[p] != own_b[p]) diff++;
         check(diff == 0, "R6 order independent owners", diff, 0);
      end

      // R9: seventeen identifiers, the last one is dropped
      nrec = 17;
      for (int r = 0; r < nrec; r++) begin
         rx[r] = r; ry[r] = 1; rd[r] = 5; rp[r] = 100 + r;
      end
      run_tile("R9 list limit", 1'b0);
      check(gn == 16, "R9 seventeenth id discarded", gn, 16);

      // R10 R4: only invalid ids and far depths, nothing visible
      nrec = 6;
      for (int r = 0; r < nrec; r++) begin
         rx[r] = r; ry[r] = 9; rd[r] = (r < 3) ? 1 : 65535; rp[r] = (r < 3) ? 255 : 4;
      end
      run_tile("R10 empty tile", 1'b0);
      check(gn == 0, "R10 R4 no output for empty tile", gn, 0);
      check(tile_busy === 1'b0, "R10 back to idle", int'(tile_busy), 0);

      // R2 R4 R5 R7: random dense tiles with ties, invalid ids and stalls
      for (int t = 0; t < 4; t++) begin
         int np;
         np = $urandom_range(2, 5);
         nrec = $urandom_range(60, 300);
         for (int r = 0; r < nrec; r++) begin
            rx[r] = (t == 3) ? $urandom_range(0, 31) : $urandom_range(0, 9);
            ry[r] = (t == 3) ? $urandom_range(0, 31) : $urandom_range(0, 9);
            rd[r] = $urandom_range(0, 31);
            rp[r] = ($urandom_range(0, 9) == 0) ? 255 : 40 + 3 * $urandom_range(0, np - 1);
         end
         run_tile("R5 R7 random tile", 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule